// File: doc/BRIEF.md
# USB Host Clock and Reset Bring-Up Sequencer

This block is a synchronous state machine that powers up the clocks and resets of a USB host controller and its PHY without software stepping through the order. It drives dedicated control lines: the interface clock enable, the PHY power-on reset, the PHY reset release, the host reset release, and the reset-release and enable lines of the host-clock and full/low-speed clock dividers. It also drives the PHY test reset, the host clock divider value, per-port PHY transmit tuning fields and the micro-frame length adjust value. Every wall-clock wait is counted in cycles of the block clock. The count for each wait is worked out at elaboration from the `CLK_FREQ_HZ` parameter, rounded up, and is never less than one cycle.

Several clients may each ask for the clocks. A use count tracks them. Only the start request that moves the count from zero to one runs the sequence. Stop requests only lower the count and never undo anything. If the host reset is already seen as released once the interface clock is on, the reset steps are skipped and only the final tuning step is applied.

Top module: `usbh_bringup_seq`

## Requirements
- R1: A start request raises the use count and a stop request lowers it. A stop at a count of zero leaves it at zero. A start and a stop in the same cycle leave it unchanged. Only a start that finds the count at zero, with no stop in the same cycle and the block idle, launches the sequence. A stop never changes any control output.
- R2: In the cycle after a launching start is sampled, busy and the interface clock enable are both high. If the host-reset-released flag is high in the next cycle, the sequence goes straight to post-configuration and completes within 5 cycles of the start, without raising the PHY power-on reset.
- R3: On entry to the reset steps, the PHY power-on reset rises while these lines are all low: host reset release, PHY reset release, both divider reset releases and both divider enables.
- R4: The host divider value is taken from q, the IO clock rate divided by 130 MHz. q = 0 gives 1. q from 1 to 4 gives q. q = 5 gives 4. q of 6 or 7 gives 6. q from 8 to 11 gives 8. q of 12 or more gives 12.
- R5: The host divider enable rises before the host divider reset release. The PHY power-on reset falls at least `IO_WAIT_CYC` (64) cycles after that release.
- R6: At least 1 ms after the power-on reset falls, the PHY test reset goes high for at least 10 ns. After it drops, the block waits at least 20 ns before the full/low-speed divider reset is released.
- R7: The full/low-speed divider reset release rises before its enable. The PHY reset release follows the enable by at least 64 cycles. The host reset release follows the PHY reset release by at least 1 µs, and it is the last release in the sequence.
- R8: Post-configuration sets, for each of ports 0 and 1, the 4-bit transmit reference-voltage tune to 15, the 2-bit rise-time tune to 1 and the 2-bit pre-emphasis tune to 1. Port n occupies slice n of each packed output. It sets the 6-bit frame length adjust to 0x20.
- R9: Busy stays high until post-configuration ends. Done then pulses high for exactly one cycle, and busy is low in that cycle.
- R10: Start and stop requests that arrive while busy still change the use count but do not restart or stop the running sequence.
- R11: A synchronous active-high reset drives every output to zero, clears the use count and returns the machine to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Use-count increment request, one cycle |
| stop_req | input | 1 | Use-count decrement request, one cycle |
| io_ratio | input | QW | IO clock rate divided by 130 MHz |
| host_up_i | input | 1 | Host reset is already released |
| if_clk_en_o | output | 1 | Interface clock enable |
| phy_por_o | output | 1 | PHY power-on reset |
| phy_rst_rel_o | output | 1 | PHY reset release |
| host_rst_rel_o | output | 1 | Host reset release |
| hdiv_rst_rel_o | output | 1 | Host clock divider reset release |
| hdiv_en_o | output | 1 | Host clock divider enable |
| odiv_rst_rel_o | output | 1 | Full/low-speed divider reset release |
| odiv_en_o | output | 1 | Full/low-speed divider enable |
| phy_test_rst_o | output | 1 | PHY test reset pulse |
| host_div_o | output | 4 | Host clock divider value |
| tx_vref_tune_o | output | NPORT*4 | Per-port reference-voltage tune |
| tx_rise_tune_o | output | NPORT*2 | Per-port rise-time tune |
| tx_preemph_o | output | NPORT*2 | Per-port pre-emphasis tune |
| frame_adj_o | output | 6 | Micro-frame length adjust |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that start and stop requests are single-cycle pulses and that `io_ratio` and `host_up_i` stay steady while the block is busy. The bench changes them only between runs, while the block is idle. The ordering assertions also assume that reset is not raised in the middle of a release step. Where the bench does reset mid-sequence, the reset falls inside a long wait, so no release edge is interrupted. The bench scales `CLK_FREQ_HZ` down so that each 1 ms wait lasts 2000 cycles. The 10 ns and 20 ns waits then round up to the one-cycle minimum, which exercises the floor.

// File: rtl/usbh_bringup_pkg.sv
package usbh_bringup_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHECK, ST_SETDIV, ST_HDEN, ST_HDREL, ST_WAIT, ST_PORCLR,
    ST_TSTHI, ST_TSTLO, ST_ODREL, ST_ODEN, ST_PHYREL, ST_HOSTREL, ST_POST
  } seq_state_e;

  // Wall-clock nanoseconds to clock cycles, rounded up, never below one.
  function automatic longint unsigned ns_to_cycles(longint unsigned ns,
                                                   longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return c;
  endfunction

  // Host divider from the IO-clock / 130 MHz quotient.
  function automatic logic [3:0] pick_host_div(int unsigned q);
    if (q == 0)       return 4'd1;
    else if (q <= 4)  return 4'(q);
    else if (q == 5)  return 4'd4;
    else if (q <= 7)  return 4'd6;
    else if (q <= 11) return 4'd8;
    else              return 4'd12;
  endfunction

endpackage

// File: rtl/usbh_use_count.sv
module usbh_use_count #(
  parameter int CW = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic stop_req,
  input  logic busy,
  output logic launch
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] cnt;
  logic          inc, dec;

  assign inc    = start_req && !stop_req && (cnt != CMAX);
  assign dec    = stop_req && !start_req && (cnt != '0);
  assign launch = start_req && !stop_req && (cnt == '0) && !busy;

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
    else if (dec) cnt <= cnt - 1'b1;
  end

  // R1
  stop_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_req && !start_req && cnt == '0) |=> cnt == '0);
  // R1
  launch_count_chk: assert property (@(posedge clk) disable iff (rst)
    launch |=> cnt == CW'(1));
endmodule

// File: rtl/usbh_wait_timer.sv
module usbh_wait_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expire
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == TW'(1));

  // R6
  nonzero_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> load_val != '0);
  // R6
  expire_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && !load) |=> cnt == '0);
endmodule

// File: rtl/usbh_bringup_seq.sv
module usbh_bringup_seq
  import usbh_bringup_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 100_000_000,
  parameter int IO_WAIT_CYC = 64,
  parameter int NPORT       = 2,
  parameter int QW          = 8,
  parameter int CW          = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_req,
  input  logic               stop_req,
  input  logic [QW-1:0]      io_ratio,
  input  logic               host_up_i,
  output logic               if_clk_en_o,
  output logic               phy_por_o,
  output logic               phy_rst_rel_o,
  output logic               host_rst_rel_o,
  output logic               hdiv_rst_rel_o,
  output logic               hdiv_en_o,
  output logic               odiv_rst_rel_o,
  output logic               odiv_en_o,
  output logic               phy_test_rst_o,
  output logic [3:0]         host_div_o,
  output logic [NPORT*4-1:0] tx_vref_tune_o,
  output logic [NPORT*2-1:0] tx_rise_tune_o,
  output logic [NPORT*2-1:0] tx_preemph_o,
  output logic [5:0]         frame_adj_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam longint unsigned HZ    = longint'(CLK_FREQ_HZ);
  localparam longint unsigned T_1MS = ns_to_cycles(64'd1_000_000, HZ);
  localparam longint unsigned T_1US = ns_to_cycles(64'd1_000, HZ);
  localparam longint unsigned T_10N = ns_to_cycles(64'd10, HZ);
  localparam longint unsigned T_20N = ns_to_cycles(64'd20, HZ);
  localparam longint unsigned T_IO  = longint'(IO_WAIT_CYC);
  localparam longint unsigned T_MAX = (T_1MS > T_IO) ? T_1MS : T_IO;
  localparam int              TW    = $clog2(T_MAX + 1) + 1;

  seq_state_e    state, ret_state;
  logic          launch, tmr_load, tmr_expire;
  logic [TW-1:0] tmr_val;

  assign busy_o = (state != ST_IDLE);

  usbh_use_count #(.CW(CW)) u_count (
    .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
    .busy(busy_o), .launch(launch)
  );

  usbh_wait_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .expire(tmr_expire)
  );

  // Timer load requests come from the release steps that precede a wait.
  always_comb begin
    tmr_load = 1'b1;
    unique case (state)
      ST_HDREL:  tmr_val = TW'(T_IO);
      ST_PORCLR: tmr_val = TW'(T_1MS);
      ST_TSTHI:  tmr_val = TW'(T_10N);
      ST_TSTLO:  tmr_val = TW'(T_20N);
      ST_ODEN:   tmr_val = TW'(T_IO);
      ST_PHYREL: tmr_val = TW'(T_1US);
      default: begin tmr_load = 1'b0; tmr_val = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;       ret_state <= ST_IDLE;
      if_clk_en_o <= 1'b0;    phy_por_o <= 1'b0;
      phy_rst_rel_o <= 1'b0;  host_rst_rel_o <= 1'b0;
      hdiv_rst_rel_o <= 1'b0; hdiv_en_o <= 1'b0;
      odiv_rst_rel_o <= 1'b0; odiv_en_o <= 1'b0;
      phy_test_rst_o <= 1'b0; host_div_o <= '0;
      tx_vref_tune_o <= '0;   tx_rise_tune_o <= '0;
      tx_preemph_o <= '0;     frame_adj_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: if (launch) begin
          if_clk_en_o <= 1'b1;
          state       <= ST_CHECK;
        end
        ST_CHECK: if (host_up_i) state <= ST_POST;
        else begin
          phy_por_o      <= 1'b1;
          host_rst_rel_o <= 1'b0; phy_rst_rel_o <= 1'b0;
          hdiv_rst_rel_o <= 1'b0; odiv_rst_rel_o <= 1'b0;
          hdiv_en_o      <= 1'b0; odiv_en_o     <= 1'b0;
          phy_test_rst_o <= 1'b0;
          state          <= ST_SETDIV;
        end
        ST_SETDIV: begin
          host_div_o <= pick_host_div(int'(io_ratio));
          state      <= ST_HDEN;
        end
        ST_HDEN:    begin hdiv_en_o <= 1'b1; state <= ST_HDREL; end
        ST_HDREL:   begin hdiv_rst_rel_o <= 1'b1; ret_state <= ST_PORCLR; state <= ST_WAIT; end
        ST_WAIT:    if (tmr_expire) state <= ret_state;
        ST_PORCLR:  begin phy_por_o <= 1'b0; ret_state <= ST_TSTHI; state <= ST_WAIT; end
        ST_TSTHI:   begin phy_test_rst_o <= 1'b1; ret_state <= ST_TSTLO; state <= ST_WAIT; end
        ST_TSTLO:   begin phy_test_rst_o <= 1'b0; ret_state <= ST_ODREL; state <= ST_WAIT; end
        ST_ODREL:   begin odiv_rst_rel_o <= 1'b1; state <= ST_ODEN; end
        ST_ODEN:    begin odiv_en_o <= 1'b1; ret_state <= ST_PHYREL; state <= ST_WAIT; end
        ST_PHYREL:  begin phy_rst_rel_o <= 1'b1; ret_state <= ST_HOSTREL; state <= ST_WAIT; end
        ST_HOSTREL: begin host_rst_rel_o <= 1'b1; state <= ST_POST; end
        ST_POST: begin
          for (int p = 0; p < NPORT; p++) begin
            tx_vref_tune_o[p*4 +: 4] <= 4'd15;
            tx_rise_tune_o[p*2 +: 2] <= 2'd1;
            tx_preemph_o[p*2 +: 2]   <= 2'd1;
          end
          frame_adj_o <= 6'h20;
          done_o      <= 1'b1;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  hdiv_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hdiv_rst_rel_o) |-> hdiv_en_o && phy_por_o);
  // R7
  odiv_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(odiv_en_o) |-> odiv_rst_rel_o);
  // R7
  host_last_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(host_rst_rel_o) |-> phy_rst_rel_o && odiv_en_o && !phy_por_o);
  // R6
  test_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    phy_test_rst_o |-> !phy_por_o && !odiv_rst_rel_o);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R4
  div_legal_chk: assert property (@(posedge clk) disable iff (rst)
    host_div_o inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8, 4'd12});
  // R2
  launch_ifclk_chk: assert property (@(posedge clk) disable iff (rst)
    launch |=> if_clk_en_o && busy_o);
endmodule

// File: tb/usbh_bringup_seq_tb.sv
module usbh_bringup_seq_tb;
  localparam int HZ   = 2_000_000;
  localparam int W1MS = 2000;
  localparam int W1US = 2;
  localparam int W10  = 1;
  localparam int W20  = 1;
  localparam int WIO  = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, start_req = 1'b0, stop_req = 1'b0, host_up = 1'b0;
  logic [7:0] io_ratio = '0;
  logic if_clk_en, phy_por, phy_rst_rel, host_rst_rel, hdiv_rst_rel, hdiv_en;
  logic odiv_rst_rel, odiv_en, phy_test_rst, busy, done;
  logic [3:0] host_div;
  logic [7:0] vref;
  logic [3:0] rise, preemph;
  logic [5:0] frame_adj;

  usbh_bringup_seq #(.CLK_FREQ_HZ(HZ)) u_dut (
    .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
    .io_ratio(io_ratio), .host_up_i(host_up), .if_clk_en_o(if_clk_en),
    .phy_por_o(phy_por), .phy_rst_rel_o(phy_rst_rel), .host_rst_rel_o(host_rst_rel),
    .hdiv_rst_rel_o(hdiv_rst_rel), .hdiv_en_o(hdiv_en), .odiv_rst_rel_o(odiv_rst_rel),
    .odiv_en_o(odiv_en), .phy_test_rst_o(phy_test_rst), .host_div_o(host_div),
    .tx_vref_tune_o(vref), .tx_rise_tune_o(rise), .tx_preemph_o(preemph),
    .frame_adj_o(frame_adj), .busy_o(busy), .done_o(done)
  );

  int n_chk = 0, n_fail = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  longint t_hen, t_hrr, t_porr, t_porf, t_tr, t_tf, t_orr, t_oen, t_prr, t_hrel;
  int done_cnt;
  bit prep_ok, busy_at_done;
  logic p_hen = 0, p_hrr = 0, p_por = 0, p_tst = 0, p_orr = 0, p_oen = 0, p_prr = 0, p_hrel = 0;

  always @(negedge clk) begin
    if (hdiv_en && !p_hen) t_hen = cyc;
    if (hdiv_rst_rel && !p_hrr) t_hrr = cyc;
    if (phy_por && !p_por) begin
      t_porr = cyc;
      prep_ok = !host_rst_rel && !phy_rst_rel && !hdiv_en && !hdiv_rst_rel
                && !odiv_en && !odiv_rst_rel;
    end
    if (!phy_por && p_por) t_porf = cyc;
    if (phy_test_rst && !p_tst) t_tr = cyc;
    if (!phy_test_rst && p_tst) t_tf = cyc;
    if (odiv_rst_rel && !p_orr) t_orr = cyc;
    if (odiv_en && !p_oen) t_oen = cyc;
    if (phy_rst_rel && !p_prr) t_prr = cyc;
    if (host_rst_rel && !p_hrel) t_hrel = cyc;
    if (done === 1'b1) begin done_cnt++; busy_at_done = busy; end
    p_hen = hdiv_en; p_hrr = hdiv_rst_rel; p_por = phy_por; p_tst = phy_test_rst;
    p_orr = odiv_rst_rel; p_oen = odiv_en; p_prr = phy_rst_rel; p_hrel = host_rst_rel;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clr_stamps();
    t_hen = -1; t_hrr = -1; t_porr = -1; t_porf = -1; t_tr = -1; t_tf = -1;
    t_orr = -1; t_oen = -1; t_prr = -1; t_hrel = -1;
    done_cnt = 0; prep_ok = 0; busy_at_done = 1;
  endtask

  task automatic pulse(input bit s, input bit p);
    @(posedge clk); #1 start_req = s; stop_req = p;
    @(posedge clk); #1 start_req = 0; stop_req = 0;
  endtask

  task automatic wait_done(input int lim);
    int n = 0;
    while (done_cnt == 0 && n < lim) begin @(negedge clk); n++; end
    @(negedge clk);
    chk(done_cnt == 1, "R9", "done pulses in run", done_cnt, 1);
  endtask

  function automatic int exp_div(input int q);
    if (q == 0) return 1;
    if (q <= 4) return q;
    if (q == 5) return 4;
    if (q <= 7) return 6;
    if (q <= 11) return 8;
    return 12;
  endfunction

  function automatic bit in_win(input longint d, input longint lo);
    return (d >= lo) && (d <= lo + 2);
  endfunction

  task automatic full_run(input int q);
    io_ratio = 8'(q); host_up = 0; clr_stamps();
    pulse(1, 0);
    @(negedge clk);
    chk(busy && if_clk_en, "R2", "busy/if clock after start", {busy, if_clk_en}, 3);
    wait_done(4000);
    chk(host_div == 4'(exp_div(q)), "R4", $sformatf("divider q=%0d", q), host_div, exp_div(q));
    chk(prep_ok, "R3", "lines low at power-on reset", prep_ok, 1);
    chk(t_hen >= 0 && t_hrr > t_hen, "R5", "host div enable before release", t_hrr, t_hen + 1);
    chk(in_win(t_porf - t_hrr, WIO), "R5", "io wait to por clear", t_porf - t_hrr, WIO);
    chk(in_win(t_tr - t_porf, W1MS), "R6", "1 ms wait", t_tr - t_porf, W1MS);
    chk(in_win(t_tf - t_tr, W10), "R6", "test reset width", t_tf - t_tr, W10);
    chk(in_win(t_orr - t_tf, W20), "R6", "post test wait", t_orr - t_tf, W20);
    chk(t_oen > t_orr, "R7", "ohci release before enable", t_oen, t_orr + 1);
    chk(in_win(t_prr - t_oen, WIO), "R7", "io wait to phy release", t_prr - t_oen, WIO);
    chk(in_win(t_hrel - t_prr, W1US), "R7", "1 us wait to host release", t_hrel - t_prr, W1US);
    chk(vref == 8'hFF && rise == 4'b0101 && preemph == 4'b0101, "R8", "port tuning",
        {vref, rise, preemph}, {8'hFF, 4'b0101, 4'b0101});
    chk(frame_adj == 6'h20, "R8", "frame adjust", frame_adj, 6'h20);
    chk(!busy_at_done && !busy, "R9", "busy low at done", busy_at_done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int dir_q [10] = '{0, 1, 4, 5, 6, 7, 8, 11, 12, 255};
    void'($urandom(32'd4242));
    clr_stamps();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({if_clk_en, phy_por, host_rst_rel, busy, done, host_div, frame_adj, vref} == '0,
        "R11", "reset state", busy, 0);
    #1 rst = 0;

    foreach (dir_q[i]) begin full_run(dir_q[i]); pulse(0, 1); end
    for (int k = 0; k < 4; k++) begin full_run(int'($urandom % 40)); pulse(0, 1); end

    // R1: use count gating, count now 0
    full_run(3);                         // count 1
    pulse(1, 0); @(negedge clk);         // count 2
    chk(!busy, "R1", "second start no launch", busy, 0);
    pulse(0, 1); pulse(1, 0); @(negedge clk);  // 1 then 2
    chk(!busy, "R1", "start at count 1 no launch", busy, 0);
    pulse(0, 1); pulse(0, 1); pulse(0, 1); @(negedge clk); // floor at 0
    chk(host_rst_rel && hdiv_en && odiv_en, "R1", "stop leaves outputs", host_rst_rel, 1);
    pulse(1, 1); @(negedge clk);
    chk(!busy, "R1", "start with stop no launch", busy, 0);

    // R2: host already up -> skip path
    host_up = 1; clr_stamps();
    pulse(1, 0);
    repeat (5) @(negedge clk);
    chk(done_cnt == 1, "R2", "skip path done within 5", done_cnt, 1);
    chk(t_porr == -1, "R2", "skip path no power-on reset", t_porr, -1);
    chk(!done, "R9", "done is single cycle", done, 0);

    // R10: requests during busy update count, no restart
    pulse(0, 1); host_up = 0; clr_stamps(); io_ratio = 8'd9;
    pulse(1, 0);
    repeat (100) @(negedge clk);
    pulse(1, 0); pulse(0, 1); pulse(0, 1);  // 2, 1, 0
    @(negedge clk);
    chk(busy && done_cnt == 0, "R10", "busy kept after requests", busy, 1);
    wait_done(4000);
    pulse(1, 0); @(negedge clk);
    chk(busy, "R10", "count changed while busy allows launch", busy, 1);

    // R11: reset mid-run clears outputs and the count
    repeat (300) @(negedge clk);
    rst = 1; repeat (2) @(posedge clk); @(negedge clk);
    chk({if_clk_en, phy_por, hdiv_en, hdiv_rst_rel, busy, host_div} == '0, "R11",
        "mid-run reset", {if_clk_en, phy_por, busy}, 0);
    rst = 0; clr_stamps();
    pulse(1, 0); @(negedge clk);
    chk(busy, "R11", "count cleared by reset", busy, 1);
    wait_done(4000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule